// File: doc/BRIEF.md
# Timer Capture/Compare Unit

This block sits beside a free-running 16-bit timer that is clocked from the system clock. It holds one 16-bit register with two uses. In capture mode the register takes a snapshot of the timer when a chosen edge arrives on an external event input. In compare mode the register holds a target value that is checked against the timer on every clock cycle, and a match starts the action that the mode selects.

A 4-bit mode word is written by the host. The match actions are: drive the compare pin high, drive the compare pin low, raise the flag only, or the special-event trigger. The special-event trigger sends a one-cycle pulse to the timer to reset it, and a one-cycle start pulse to an external A/D converter when the converter is enabled. Every capture and every match sets a sticky interrupt flag. The host clears that flag with a write-one-to-clear strobe, and an enable input masks the flag before it reaches the interrupt line.

The timer, the direction control of the pin and the converter are outside the block. The timer value must be synchronous to the block's clock.

Top module: `tmr_cc_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, cap_reg is 0 and cmp_pin, irq_flag, irq, tmr_rst and adc_start are all 0.
- R2: With mode 0101, a rising edge on evt_in copies tmr_val into cap_reg and sets irq_flag. A falling edge causes no capture. A level that stays high causes no further capture.
- R3: With mode 0100, a falling edge on evt_in copies tmr_val into cap_reg and sets irq_flag. A rising edge causes no capture.
- R4: A reg_wr strobe loads reg_in into the register, and the new value shows on cap_reg in the next cycle. Outside the capture modes, only reg_wr changes the register.
- R5: Writing mode 1000 drives cmp_pin to 0. The first cycle in which tmr_val equals the register then drives cmp_pin to 1 and sets irq_flag.
- R6: Writing mode 1001 drives cmp_pin to 1. The first match then drives cmp_pin to 0 and sets irq_flag.
- R7: In mode 1010 a match sets irq_flag and leaves cmp_pin at 0.
- R8: In mode 1011 a match gives tmr_rst a pulse of exactly one cycle. adc_start pulses in the same cycle only when adc_en is 1.
- R9: A match action fires once, in the cycle after the timer first equals the register. While the two values stay equal, the action does not fire again.
- R10: irq_flag stays set until flag_clr is 1. If a new capture or match arrives in the same cycle as flag_clr, the flag stays set.
- R11: irq is 1 only when irq_flag is 1 and irq_en is 1.
- R12: Mode 0000 and every mode code not listed above do nothing: no capture, no match action, and cmp_pin stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_val | input | 16 | Current timer value |
| evt_in | input | 1 | External event input, asynchronous |
| mode_wr | input | 1 | Strobe that loads mode_in |
| mode_in | input | 4 | New mode code |
| reg_wr | input | 1 | Strobe that loads reg_in |
| reg_in | input | 16 | New value for the capture/compare register |
| flag_clr | input | 1 | Write-one-to-clear strobe for irq_flag |
| irq_en | input | 1 | Interrupt mask; 1 lets the flag through |
| adc_en | input | 1 | Converter enabled; gates adc_start |
| cap_reg | output | 16 | Capture/compare register value |
| cmp_pin | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Flag after masking by irq_en |
| tmr_rst | output | 1 | One-cycle request to reset the timer |
| adc_start | output | 1 | One-cycle request to start a conversion |

## Verification
Some properties are checked on every cycle. The flag stays set until it is cleared. A timer-reset pulse never lasts two cycles, comes only from the special-event mode, and goes with every converter start. The register never moves outside a capture mode unless the host writes it. The pin rises only because of the set-on-match mode or a mode write.

Other behaviour can only be shown by the bench scenarios. These include the captured value and the edge polarity, the pin level after each kind of match, the set-over-clear priority and the masking. They also include the latency through the synchronizer, and that an equal value held for many cycles gives a single action.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [3:0] {
        MD_OFF         = 4'b0000,
        MD_CAP_FALL    = 4'b0100,
        MD_CAP_RISE    = 4'b0101,
        MD_CMP_SET     = 4'b1000,
        MD_CMP_CLR     = 4'b1001,
        MD_CMP_FLAG    = 4'b1010,
        MD_CMP_SPECIAL = 4'b1011
    } tcc_mode_e;

    typedef struct packed {
        logic is_cap;
        logic cap_rise;
        logic is_cmp;
        logic pin_set;
        logic pin_clr;
        logic special;
    } tcc_ctrl_t;

    function automatic tcc_mode_e tcc_decode(input logic [3:0] raw);
        tcc_mode_e m;
        case (raw)
            4'b0100: m = MD_CAP_FALL;
            4'b0101: m = MD_CAP_RISE;
            4'b1000: m = MD_CMP_SET;
            4'b1001: m = MD_CMP_CLR;
            4'b1010: m = MD_CMP_FLAG;
            4'b1011: m = MD_CMP_SPECIAL;
            default: m = MD_OFF;
        endcase
        return m;
    endfunction

    function automatic tcc_ctrl_t tcc_ctrl(input tcc_mode_e m);
        tcc_ctrl_t c;
        c = '0;
        case (m)
            MD_CAP_FALL:    c.is_cap = 1'b1;
            MD_CAP_RISE:    begin c.is_cap = 1'b1; c.cap_rise = 1'b1; end
            MD_CMP_SET:     begin c.is_cmp = 1'b1; c.pin_set = 1'b1; end
            MD_CMP_CLR:     begin c.is_cmp = 1'b1; c.pin_clr = 1'b1; end
            MD_CMP_FLAG:    c.is_cmp = 1'b1;
            MD_CMP_SPECIAL: begin c.is_cmp = 1'b1; c.special = 1'b1; end
            default:        c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign fall = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tmr,
    input  logic [W-1:0] target,
    input  logic         arm,
    output logic         hit
);
    logic eq;
    logic eq_q;

    assign eq = (tmr == target);

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    assign hit = arm & eq & ~eq_q;
endmodule

// File: rtl/tcc_action.sv
module tcc_action
    import tcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tcc_ctrl_t ctrl,
    input  logic      mode_load,
    input  tcc_ctrl_t next_ctrl,
    input  logic      hit,
    input  logic      capture,
    input  logic      flag_clr,
    input  logic      adc_en,
    output logic      pin,
    output logic      flag,
    output logic      tmr_rst,
    output logic      adc_start
);
    logic flag_set;

    assign flag_set = capture | hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (mode_load) begin
            pin <= next_ctrl.pin_clr;
        end else if (hit && ctrl.pin_set) begin
            pin <= 1'b1;
        end else if (hit && ctrl.pin_clr) begin
            pin <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_rst   <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            tmr_rst   <= hit & ctrl.special;
            adc_start <= hit & ctrl.special & adc_en;
        end
    end
endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
    import tcc_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             evt_in,
    input  logic             mode_wr,
    input  logic [3:0]       mode_in,
    input  logic             reg_wr,
    input  logic [TMR_W-1:0] reg_in,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             adc_en,
    output logic [TMR_W-1:0] cap_reg,
    output logic             cmp_pin,
    output logic             irq_flag,
    output logic             irq,
    output logic             tmr_rst,
    output logic             adc_start
);
    tcc_mode_e        mode_q;
    tcc_ctrl_t        ctrl;
    tcc_ctrl_t        next_ctrl;
    logic [TMR_W-1:0] cc_q;
    logic             evt_rise;
    logic             evt_fall;
    logic             capture;
    logic             hit;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MD_OFF;
        else if (mode_wr) mode_q <= tcc_decode(mode_in);
    end

    assign ctrl      = tcc_ctrl(mode_q);
    assign next_ctrl = tcc_ctrl(tcc_decode(mode_in));

    tcc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (evt_in),
        .rise (evt_rise),
        .fall (evt_fall)
    );

    assign capture = ctrl.is_cap & (ctrl.cap_rise ? evt_rise : evt_fall);

    always_ff @(posedge clk) begin
        if (rst)          cc_q <= '0;
        else if (capture) cc_q <= tmr_val;
        else if (reg_wr)  cc_q <= reg_in;
    end

    tcc_match #(.W(TMR_W)) u_match (
        .clk    (clk),
        .rst    (rst),
        .tmr    (tmr_val),
        .target (cc_q),
        .arm    (ctrl.is_cmp),
        .hit    (hit)
    );

    tcc_action u_act (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mode_load (mode_wr),
        .next_ctrl (next_ctrl),
        .hit       (hit),
        .capture   (capture),
        .flag_clr  (flag_clr),
        .adc_en    (adc_en),
        .pin       (cmp_pin),
        .flag      (irq_flag),
        .tmr_rst   (tmr_rst),
        .adc_start (adc_start)
    );

    assign cap_reg = cc_q;
    assign irq     = irq_flag & irq_en;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       mode_q,
    input logic             mode_wr,
    input logic             reg_wr,
    input logic             flag_clr,
    input logic             adc_en,
    input logic [TMR_W-1:0] cap_reg,
    input logic             cmp_pin,
    input logic             irq_flag,
    input logic             tmr_rst,
    input logic             adc_start
);
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr) |=> irq_flag);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |=> !tmr_rst);

    assert_adc_with_reset_R8: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (tmr_rst && $past(adc_en)));

    assert_reset_from_special_R8: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |-> ($past(mode_q) == 4'b1011));

    assert_reg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && mode_q[3:1] != 3'b010) |=> $stable(cap_reg));

    assert_pin_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_pin) |-> ($past(mode_q) == 4'b1000 || $past(mode_wr)));
endmodule

bind tmr_cc_unit tcc_checker #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .mode_wr   (mode_wr),
    .reg_wr    (reg_wr),
    .flag_clr  (flag_clr),
    .adc_en    (adc_en),
    .cap_reg   (cap_reg),
    .cmp_pin   (cmp_pin),
    .irq_flag  (irq_flag),
    .tmr_rst   (tmr_rst),
    .adc_start (adc_start)
);

// File: tb/tmr_cc_unit_test.sv
`timescale 1ns/1ps
module tmr_cc_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_val = '0;
    logic        evt_in = 1'b0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_in = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_in = '0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        adc_en = 1'b0;
    logic [15:0] cap_reg;
    logic        cmp_pin, irq_flag, irq, tmr_rst, adc_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_cc_unit uut (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .evt_in(evt_in),
        .mode_wr(mode_wr), .mode_in(mode_in), .reg_wr(reg_wr), .reg_in(reg_in),
        .flag_clr(flag_clr), .irq_en(irq_en), .adc_en(adc_en),
        .cap_reg(cap_reg), .cmp_pin(cmp_pin), .irq_flag(irq_flag), .irq(irq),
        .tmr_rst(tmr_rst), .adc_start(adc_start)
    );

    // mode, register, match timer, adc_en, expected pin/flag/tmr_rst/adc_start
    localparam int NV = 9;
    localparam logic [40:0] VEC [NV] = '{
        {4'b1000, 16'h1234, 16'h1234, 1'b0, 4'b1100},  // R5 set on match
        {4'b1000, 16'h1234, 16'h1235, 1'b0, 4'b0000},  // R5 no match
        {4'b1001, 16'h00FF, 16'h00FF, 1'b0, 4'b0100},  // R6 clear on match
        {4'b1001, 16'h00FF, 16'h00FE, 1'b0, 4'b1000},  // R6 no match
        {4'b1010, 16'hABCD, 16'hABCD, 1'b0, 4'b0100},  // R7 flag only
        {4'b1011, 16'h8000, 16'h8000, 1'b1, 4'b0111},  // R8 with adc
        {4'b1011, 16'h8000, 16'h8000, 1'b0, 4'b0110},  // R8 without adc
        {4'b0000, 16'h5555, 16'h5555, 1'b1, 4'b0000},  // R12 off
        {4'b0110, 16'h5555, 16'h5555, 1'b1, 4'b0000}   // R12 undefined code
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode_wr = 1'b1; mode_in = m;
        tick(1);
        mode_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 cap_reg", cap_reg, 16'h0);
        check("R1 cmp_pin", {15'b0, cmp_pin}, 16'h0);
        check("R1 irq_flag", {15'b0, irq_flag}, 16'h0);
        rst = 1'b0;
        tick(1);
        check("R1 cap_reg after release", cap_reg, 16'h0);
        check("R1 pulses", {12'b0, cmp_pin, irq, tmr_rst, adc_start}, 16'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  vm;
            logic [15:0] vr, vt;
            vm = VEC[i][40:37]; vr = VEC[i][36:21]; vt = VEC[i][20:5];
            adc_en = VEC[i][4];
            mode_wr = 1'b1; mode_in = vm;
            reg_wr = 1'b1; reg_in = vr;
            flag_clr = 1'b1;
            tmr_val = ~vr;
            tick(1);
            mode_wr = 1'b0; reg_wr = 1'b0; flag_clr = 1'b0;
            tick(1);
            tmr_val = vt;
            tick(1);
            check($sformatf("vec%0d cmp_pin R5/R6/R7", i), {15'b0, cmp_pin}, {15'b0, VEC[i][3]});
            check($sformatf("vec%0d irq_flag R7/R12", i), {15'b0, irq_flag}, {15'b0, VEC[i][2]});
            check($sformatf("vec%0d tmr_rst R8", i), {15'b0, tmr_rst}, {15'b0, VEC[i][1]});
            check($sformatf("vec%0d adc_start R8", i), {15'b0, adc_start}, {15'b0, VEC[i][0]});
        end

        // R9: special mode, hold match for many cycles
        adc_en = 1'b1;
        set_mode(4'b1011);
        reg_wr = 1'b1; reg_in = 16'h0400; tmr_val = 16'h0000; flag_clr = 1'b1;
        tick(1);
        reg_wr = 1'b0; flag_clr = 1'b0;
        tick(1);
        tmr_val = 16'h0400;
        tick(1);
        check("R9 first pulse", {15'b0, tmr_rst}, 16'h1);
        tick(1);
        check("R9 pulse ends", {15'b0, tmr_rst}, 16'h0);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        tick(5);
        check("R9 no refire flag", {15'b0, irq_flag}, 16'h0);
        check("R9 no refire adc", {15'b0, adc_start}, 16'h0);

        // R10: set beats clear in the same cycle; sticky
        tmr_val = 16'h0000;
        tick(1);
        tmr_val = 16'h0400; flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R10 set wins", {15'b0, irq_flag}, 16'h1);
        tick(6);
        check("R10 sticky", {15'b0, irq_flag}, 16'h1);

        // R11: masking
        irq_en = 1'b0;
        tick(1);
        check("R11 masked", {15'b0, irq}, 16'h0);
        irq_en = 1'b1;
        tick(1);
        check("R11 enabled", {15'b0, irq}, 16'h1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R10 cleared", {15'b0, irq_flag}, 16'h0);
        check("R11 cleared", {15'b0, irq}, 16'h0);

        // R2: rising-edge capture
        set_mode(4'b0101);
        tmr_val = 16'h1111; evt_in = 1'b1;
        tick(4);
        check("R2 capture value", cap_reg, 16'h1111);
        check("R2 flag", {15'b0, irq_flag}, 16'h1);
        flag_clr = 1'b1; tmr_val = 16'h2222;
        tick(1);
        flag_clr = 1'b0;
        tick(4);
        check("R2 high level no recapture", cap_reg, 16'h1111);
        evt_in = 1'b0;
        tick(4);
        check("R2 falling ignored", cap_reg, 16'h1111);
        check("R2 falling no flag", {15'b0, irq_flag}, 16'h0);

        // R3: falling-edge capture
        set_mode(4'b0100);
        tmr_val = 16'h3333; evt_in = 1'b1;
        tick(4);
        check("R3 rising ignored", cap_reg, 16'h1111);
        evt_in = 1'b0;
        tick(4);
        check("R3 capture value", cap_reg, 16'h3333);
        check("R3 flag", {15'b0, irq_flag}, 16'h1);
        tmr_val = 16'h4444;
        tick(4);
        check("R3 one capture per edge", cap_reg, 16'h3333);

        // R4: host write, then no change from events outside capture modes
        flag_clr = 1'b1;
        set_mode(4'b1010);
        flag_clr = 1'b0;
        reg_wr = 1'b1; reg_in = 16'h0F0F; tmr_val = 16'h0000;
        tick(1);
        reg_wr = 1'b0;
        check("R4 host write", cap_reg, 16'h0F0F);
        set_mode(4'b0000);
        evt_in = 1'b1;
        tick(4);
        evt_in = 1'b0;
        tick(4);
        check("R12 off no capture", cap_reg, 16'h0F0F);
        check("R12 off no flag", {15'b0, irq_flag}, 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule